// File: doc/BRIEF.md
# Variable-Latency Five-Stage Instruction Pipeline

This block runs a short program of register-to-register arithmetic through an in-order pipeline of five stages: fetch, decode, operand read, execute and register write. The program and the starting register values are handed in as flat vectors and latched when a start pulse arrives. Each instruction is an add, subtract, multiply or divide on an eight-entry register file. Fetch, decode, operand read and register write take one cycle each. The execute time depends on the opcode.

Execute results are forwarded out of an in-flight result queue to the operand read of a dependent instruction. A dependent instruction waits in operand read until every source it needs has finished execution, and the stages behind it hold their contents while it waits. Independent long operations overlap in the queue. Register writes leave the queue strictly in program order.

For every instruction, the block reports the cycle in which it left each stage. It also reports the final register contents and a done flag. Cycle 1 is the first cycle after the start pulse is sampled.

Top module: `pl_varlat_core`

## Requirements
- R1: An instruction word is 11 bits: bits [10:9] are the opcode (00 add, 01 subtract, 10 multiply, 11 divide), bits [8:6] the destination register, bits [5:3] source A and bits [2:0] source B.
- R2: With no hazard, an instruction leaves fetch, decode and operand read in three consecutive cycles, and the next instruction trails it by one cycle. The first instruction leaves fetch in cycle 1.
- R3: The reported last execute cycle equals the operand read cycle plus 1 for add and subtract, plus 3 for multiply and plus 6 for divide.
- R4: A consumer performs operand read no earlier than the cycle after its producer's last execute cycle. When nothing else holds it back, it performs operand read exactly in that cycle.
- R5: When the two sources come from different in-flight producers, operand read waits for whichever result finishes later.
- R6: Independent operations overlap in execution. A divide that follows a multiply with no dependence performs operand read one cycle after the multiply's operand read.
- R7: While operand read stalls, the instructions in fetch and decode hold, and their reported leave cycles move later accordingly.
- R8: Register writes happen in program order, at most one per cycle. Each write happens no earlier than the cycle after the last execute cycle.
- R9: At most 4 instructions sit between operand read and register write. An instruction performs operand read only once the instruction four places ahead of it has written back in an earlier cycle.
- R10: Results are unsigned 16-bit values: add, subtract and multiply wrap modulo 2^16, and divide truncates, with a zero divisor giving 0xFFFF. The final register contents match sequential execution of the program.
- R11: After reset, done and all register outputs are 0. Done rises after the last register write, stays high until the next start, and a start pulse while the program is running is ignored.
- R12: For multiply r2,r0,r1; divide r5,r3,r4; add r2,r5,r2; subtract r5,r2,r6, the add reads its operands in cycle 11, the subtract in cycle 13, and the last write happens in cycle 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Latches the program and initial registers and begins execution |
| prog_i | input | 176 | Sixteen 11-bit instruction words; word k sits at bits [11k+10:11k] |
| prog_len_i | input | 5 | Number of instructions to run (0 to 16) |
| rf_init_i | input | 128 | Initial register values, 16 bits each, register k at [16k+15:16k] |
| if_cyc_o | output | 192 | Per instruction, the 12-bit cycle in which it left fetch |
| id_cyc_o | output | 192 | Per instruction, the cycle in which it left decode |
| of_cyc_o | output | 192 | Per instruction, the cycle of its operand read |
| po_cyc_o | output | 192 | Per instruction, its last execute cycle |
| wo_cyc_o | output | 192 | Per instruction, its register write cycle |
| rf_o | output | 128 | Current register file contents |
| done_o | output | 1 | High once the program has fully written back |

## Verification
The sharpest collision is a write and a forward to the same register in the same cycle. The oldest queue entry writes a register in the same cycle that a consumer reads that register at operand read, so the consumer must take the value from the queue and not the stale register. In that same cycle the queue can also both accept a new entry and retire its oldest one. The bench provokes both with back-to-back dependent chains behind long divides, with a run of independent divides that fills the queue, and with random programs that mix opcodes on few registers. It judges every stage cycle and the final registers against a timing recurrence and a sequential value model computed inside the bench.

// File: rtl/pl_pkg.sv
package pl_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_DIV = 2'b11
   } op_e;
endpackage

// File: rtl/pl_alu.sv
module pl_alu
   import pl_pkg::*;
#(
   parameter int W = 16
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [2*W-1:0] prod;
   assign prod = a * b;

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = prod[W-1:0];
         default: y = (b == '0) ? '1 : a / b;
      endcase
   end
endmodule

// File: rtl/pl_regfile.sv
module pl_regfile #(
   parameter int W    = 16,
   parameter int REGS = 8,
   parameter int RA   = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [REGS*W-1:0] init,
   input  logic              we,
   input  logic [RA-1:0]     waddr,
   input  logic [W-1:0]      wdata,
   input  logic [RA-1:0]     raddr_a,
   input  logic [RA-1:0]     raddr_b,
   output logic [W-1:0]      rdata_a,
   output logic [W-1:0]      rdata_b,
   output logic [REGS*W-1:0] flat
);
   logic [W-1:0] mem [REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < REGS; k++) mem[k] <= '0;
      end else if (load) begin
         for (int k = 0; k < REGS; k++) mem[k] <= init[k*W +: W];
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

   for (genvar g = 0; g < REGS; g++) begin : g_flat
      assign flat[g*W +: W] = mem[g];
   end
endmodule

// File: rtl/pl_exq.sv
module pl_exq #(
   parameter int W   = 16,
   parameter int RA  = 3,
   parameter int QD  = 4,
   parameter int LW  = 3,
   parameter int IXW = 4,
   parameter int CW  = $clog2(QD + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           push,
   input  logic [RA-1:0]  push_dest,
   input  logic [W-1:0]   push_val,
   input  logic [LW-1:0]  push_lat,
   input  logic [IXW-1:0] push_idx,
   input  logic [RA-1:0]  qa,
   input  logic [RA-1:0]  qb,
   output logic           hit_a,
   output logic           rdy_a,
   output logic [W-1:0]   val_a,
   output logic           hit_b,
   output logic           rdy_b,
   output logic [W-1:0]   val_b,
   output logic [CW-1:0]  cnt,
   output logic           pop,
   output logic [RA-1:0]  pop_dest,
   output logic [W-1:0]   pop_val,
   output logic [IXW-1:0] pop_idx
);
   localparam int QA = $clog2(QD);

   logic [RA-1:0]  e_dest [QD];
   logic [W-1:0]   e_val  [QD];
   logic [LW-1:0]  e_rem  [QD];
   logic [IXW-1:0] e_idx  [QD];
   logic [QA-1:0]  head, tail;

   // Youngest matching entry wins: scan oldest to youngest.
   always_comb begin
      logic [QA-1:0] pos;
      hit_a = 1'b0; rdy_a = 1'b0; val_a = '0;
      hit_b = 1'b0; rdy_b = 1'b0; val_b = '0;
      for (int k = 0; k < QD; k++) begin
         pos = head + QA'(k);
         if (CW'(k) < cnt) begin
            if (e_dest[pos] == qa) begin
               hit_a = 1'b1; rdy_a = (e_rem[pos] == '0); val_a = e_val[pos];
            end
            if (e_dest[pos] == qb) begin
               hit_b = 1'b1; rdy_b = (e_rem[pos] == '0); val_b = e_val[pos];
            end
         end
      end
   end

   assign pop      = (cnt != '0) && (e_rem[head] == '0);
   assign pop_dest = e_dest[head];
   assign pop_val  = e_val[head];
   assign pop_idx  = e_idx[head];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         for (int k = 0; k < QD; k++)
            if (e_rem[k] != '0) e_rem[k] <= e_rem[k] - LW'(1);
         if (push) begin
            e_dest[tail] <= push_dest;
            e_val[tail]  <= push_val;
            e_rem[tail]  <= push_lat;
            e_idx[tail]  <= push_idx;
            tail         <= tail + QA'(1);
         end
         if (pop) head <= head + QA'(1);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/pl_varlat_core.sv
module pl_varlat_core
   import pl_pkg::*;
#(
   parameter int W       = 16,
   parameter int REGS    = 8,
   parameter int DEPTH   = 16,
   parameter int QD      = 4,
   parameter int TW      = 12,
   parameter int MUL_LAT = 3,
   parameter int DIV_LAT = 6,
   parameter int RA      = $clog2(REGS),
   parameter int IW      = 2 + 3 * RA,
   parameter int LENW    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [DEPTH*IW-1:0] prog_i,
   input  logic [LENW-1:0]     prog_len_i,
   input  logic [REGS*W-1:0]   rf_init_i,
   output logic [DEPTH*TW-1:0] if_cyc_o,
   output logic [DEPTH*TW-1:0] id_cyc_o,
   output logic [DEPTH*TW-1:0] of_cyc_o,
   output logic [DEPTH*TW-1:0] po_cyc_o,
   output logic [DEPTH*TW-1:0] wo_cyc_o,
   output logic [REGS*W-1:0]   rf_o,
   output logic                done_o
);
   localparam int IXW = $clog2(DEPTH);
   localparam int LW  = $clog2(DIV_LAT + 1);
   localparam int CW  = $clog2(QD + 1);

   if (MUL_LAT < 1 || DIV_LAT < MUL_LAT) begin : g_bad_lat
      $error("latencies must satisfy 1 <= MUL_LAT <= DIV_LAT");
   end
   if (QD < 2 || (QD & (QD - 1)) != 0) begin : g_bad_qd
      $error("QD must be a power of two, at least 2");
   end
   if ((REGS & (REGS - 1)) != 0 || DEPTH < 2) begin : g_bad_geom
      $error("REGS must be a power of two and DEPTH at least 2");
   end

   typedef struct packed {
      op_e           op;
      logic [RA-1:0] rd;
      logic [RA-1:0] ra;
      logic [RA-1:0] rb;
   } ins_t;

   logic            run;
   logic [TW-1:0]   cyc;
   logic [LENW-1:0] len_q;
   logic [IW-1:0]   prog_mem [DEPTH];
   logic            if_v, id_v, of_v;
   logic [IXW-1:0]  if_idx, id_idx, of_idx;
   ins_t            id_ins, of_ins;
   logic [TW-1:0]   t_if [DEPTH], t_id [DEPTH], t_of [DEPTH], t_po [DEPTH], t_wo [DEPTH];

   logic            launch;
   logic            hit_a, rdy_a, hit_b, rdy_b;
   logic [W-1:0]    fval_a, fval_b, rf_a, rf_b, opa, opb, res;
   logic [CW-1:0]   q_cnt;
   logic            pop;
   logic [RA-1:0]   pop_dest;
   logic [W-1:0]    pop_val;
   logic [IXW-1:0]  pop_idx;
   logic [LW-1:0]   lat;
   logic            of_go, of_free, id_free;
   logic            drained;

   assign launch = start_i && !run;

   pl_regfile #(.W(W), .REGS(REGS), .RA(RA)) u_rf (
      .clk(clk), .rst_n(rst_n), .load(launch), .init(rf_init_i),
      .we(pop), .waddr(pop_dest), .wdata(pop_val),
      .raddr_a(of_ins.ra), .raddr_b(of_ins.rb),
      .rdata_a(rf_a), .rdata_b(rf_b), .flat(rf_o)
   );

   pl_exq #(.W(W), .RA(RA), .QD(QD), .LW(LW), .IXW(IXW), .CW(CW)) u_q (
      .clk(clk), .rst_n(rst_n), .clr(launch),
      .push(of_go), .push_dest(of_ins.rd), .push_val(res), .push_lat(lat), .push_idx(of_idx),
      .qa(of_ins.ra), .qb(of_ins.rb),
      .hit_a(hit_a), .rdy_a(rdy_a), .val_a(fval_a),
      .hit_b(hit_b), .rdy_b(rdy_b), .val_b(fval_b),
      .cnt(q_cnt), .pop(pop), .pop_dest(pop_dest), .pop_val(pop_val), .pop_idx(pop_idx)
   );

   assign opa = hit_a ? fval_a : rf_a;
   assign opb = hit_b ? fval_b : rf_b;

   pl_alu #(.W(W)) u_alu (.op(of_ins.op), .a(opa), .b(opb), .y(res));

   always_comb begin
      unique case (of_ins.op)
         OP_MUL:  lat = LW'(MUL_LAT);
         OP_DIV:  lat = LW'(DIV_LAT);
         default: lat = LW'(1);
      endcase
   end

   assign of_go   = run && of_v && (!hit_a || rdy_a) && (!hit_b || rdy_b) && (q_cnt < CW'(QD));
   assign of_free = !of_v || of_go;
   assign id_free = !id_v || of_free;
   assign drained = !if_v && !id_v && !of_v && (q_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || launch) begin
         run    <= launch;
         done_o <= 1'b0;
         cyc    <= launch ? TW'(1) : '0;
         len_q  <= launch ? prog_len_i : '0;
         if_v   <= launch && (prog_len_i != '0);
         id_v   <= 1'b0;
         of_v   <= 1'b0;
         if_idx <= '0;
         id_idx <= '0;
         of_idx <= '0;
         id_ins <= '0;
         of_ins <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            prog_mem[k] <= prog_i[k*IW +: IW];
            t_if[k] <= '0; t_id[k] <= '0; t_of[k] <= '0; t_po[k] <= '0; t_wo[k] <= '0;
         end
      end else if (run) begin
         cyc <= cyc + TW'(1);
         if (of_go) begin
            t_of[of_idx] <= cyc;
            t_po[of_idx] <= cyc + TW'(lat);
         end
         if (pop) t_wo[pop_idx] <= cyc;
         if (of_free) begin
            of_v   <= id_v;
            of_idx <= id_idx;
            of_ins <= id_ins;
            if (id_v) t_id[id_idx] <= cyc;
         end
         if (id_free) begin
            id_v   <= if_v;
            id_idx <= if_idx;
            id_ins <= ins_t'(prog_mem[if_idx]);
            if (if_v) begin
               t_if[if_idx] <= cyc;
               if ((LENW'(if_idx) + LENW'(1)) < len_q) if_idx <= if_idx + IXW'(1);
               else if_v <= 1'b0;
            end
         end
         if (drained) begin
            run    <= 1'b0;
            done_o <= 1'b1;
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ts
      assign if_cyc_o[g*TW +: TW] = t_if[g];
      assign id_cyc_o[g*TW +: TW] = t_id[g];
      assign of_cyc_o[g*TW +: TW] = t_of[g];
      assign po_cyc_o[g*TW +: TW] = t_po[g];
      assign wo_cyc_o[g*TW +: TW] = t_wo[g];
   end
endmodule

// File: rtl/pl_varlat_chk.sv
module pl_varlat_chk #(
   parameter int IXW = 4,
   parameter int CW  = 3,
   parameter int QD  = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic           run,
   input logic           done_o,
   input logic           of_v,
   input logic           of_go,
   input logic [IXW-1:0] of_idx,
   input logic [CW-1:0]  q_cnt,
   input logic           pop,
   input logic [IXW-1:0] pop_idx
);
   logic [IXW-1:0] next_wb;

   always_ff @(posedge clk) begin
      if (!rst_n || (start_i && !run)) next_wb <= '0;
      else if (pop) next_wb <= next_wb + IXW'(1);
   end

   assert_wb_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (pop_idx == next_wb));

   assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CW'(QD));

   assert_issue_enqueues_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (of_go && !start_i) |=> (q_cnt != '0));

   assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (of_v && !of_go && !start_i) |=> (of_v && of_idx == $past(of_idx)));

   assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);
endmodule

bind pl_varlat_core pl_varlat_chk #(.IXW(IXW), .CW(CW), .QD(QD)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .run(run), .done_o(done_o),
   .of_v(of_v), .of_go(of_go), .of_idx(of_idx), .q_cnt(q_cnt),
   .pop(pop), .pop_idx(pop_idx)
);

// File: tb/sim_pl_varlat_core.sv
`timescale 1ns/1ps
module sim_pl_varlat_core;
   localparam int W = 16, REGS = 8, DEPTH = 16, QD = 4, TW = 12, IW = 11, LENW = 5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [DEPTH*IW-1:0] prog_i = '0;
   logic [LENW-1:0]     prog_len_i = '0;
   logic [REGS*W-1:0]   rf_init_i = '0;
   logic [DEPTH*TW-1:0] if_cyc_o, id_cyc_o, of_cyc_o, po_cyc_o, wo_cyc_o;
   logic [REGS*W-1:0]   rf_o;
   logic                done_o;

   always #2 clk = ~clk;

   pl_varlat_core u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_i(prog_i),
      .prog_len_i(prog_len_i), .rf_init_i(rf_init_i),
      .if_cyc_o(if_cyc_o), .id_cyc_o(id_cyc_o), .of_cyc_o(of_cyc_o),
      .po_cyc_o(po_cyc_o), .wo_cyc_o(wo_cyc_o), .rf_o(rf_o), .done_o(done_o)
   );

   int checks = 0, errors = 0;
   int e_if[DEPTH], e_id[DEPTH], e_of[DEPTH], e_po[DEPTH], e_wo[DEPTH];
   logic [W-1:0] e_rf[REGS];
   logic [IW-1:0] pr[DEPTH];
   logic [W-1:0]  ri[REGS];

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] enc(int op, int d, int a, int b);
      return {2'(op), 3'(d), 3'(a), 3'(b)};
   endfunction

   function automatic logic [W-1:0] alu(int op, logic [W-1:0] a, logic [W-1:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return W'(a * b);
         default: return (b == 0) ? 16'hFFFF : a / b;
      endcase
   endfunction

   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   // Timing recurrence and sequential value model.
   task automatic model(int n);
      int wr_po[REGS];
      for (int r = 0; r < REGS; r++) begin wr_po[r] = 0; e_rf[r] = ri[r]; end
      for (int i = 0; i < n; i++) begin
         int op, d, a, b, lat;
         op = int'(pr[i][10:9]); d = int'(pr[i][8:6]); a = int'(pr[i][5:3]); b = int'(pr[i][2:0]);
         lat = (op == 2) ? 3 : (op == 3) ? 6 : 1;
         e_if[i] = (i == 0) ? 1 : mx(e_if[i-1] + 1, e_id[i-1]);
         e_id[i] = mx(e_if[i] + 1, (i == 0) ? 0 : e_of[i-1]);
         e_of[i] = mx(mx(e_id[i] + 1, wr_po[a] + 1), mx(wr_po[b] + 1, (i >= QD) ? e_wo[i-QD] + 1 : 0));
         e_po[i] = e_of[i] + lat;
         e_wo[i] = mx(e_po[i] + 1, (i == 0) ? 0 : e_wo[i-1] + 1);
         wr_po[d] = e_po[i];
         e_rf[d] = alu(op, e_rf[a], e_rf[b]);
      end
   endtask

   task automatic run_prog(int n, string tag);
      int waited;
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) prog_i[i*IW +: IW] = (i < n) ? pr[i] : '0;
      for (int r = 0; r < REGS; r++) rf_init_i[r*W +: W] = ri[r];
      prog_len_i = LENW'(n);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      waited = 0;
      while (!done_o && waited < 2000) begin @(negedge clk); waited++; end
      chk("R11", {tag, " done"}, int'(done_o), 1);
      model(n);
      for (int i = 0; i < n; i++) begin
         chk("R2", $sformatf("%s if[%0d]", tag, i), int'(if_cyc_o[i*TW +: TW]), e_if[i]);
         chk("R7", $sformatf("%s id[%0d]", tag, i), int'(id_cyc_o[i*TW +: TW]), e_id[i]);
         chk("R4", $sformatf("%s of[%0d]", tag, i), int'(of_cyc_o[i*TW +: TW]), e_of[i]);
         chk("R3", $sformatf("%s po[%0d]", tag, i), int'(po_cyc_o[i*TW +: TW]), e_po[i]);
         chk("R8", $sformatf("%s wo[%0d]", tag, i), int'(wo_cyc_o[i*TW +: TW]), e_wo[i]);
      end
      for (int r = 0; r < REGS; r++)
         chk("R1 R10", $sformatf("%s r%0d", tag, r), int'(rf_o[r*W +: W]), int'(e_rf[r]));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R11", "reset done", int'(done_o), 0);
      chk("R11", "reset regs", int'(rf_o == '0), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 / R5: the dependent chain behind a multiply and a divide.
      for (int r = 0; r < REGS; r++) ri[r] = W'(r * 7 + 3);
      pr[0] = enc(2, 2, 0, 1); pr[1] = enc(3, 5, 3, 4);
      pr[2] = enc(0, 2, 5, 2); pr[3] = enc(1, 5, 2, 6);
      run_prog(4, "chain");
      chk("R12", "add operand read", int'(of_cyc_o[2*TW +: TW]), 11);
      chk("R12", "sub operand read", int'(of_cyc_o[3*TW +: TW]), 13);
      chk("R12", "last write", int'(wo_cyc_o[3*TW +: TW]), 15);
      chk("R5", "add waits for later source", int'(of_cyc_o[2*TW +: TW]), int'(po_cyc_o[1*TW +: TW]) + 1);
      chk("R6", "divide overlaps multiply", int'(of_cyc_o[1*TW +: TW]), int'(of_cyc_o[0*TW +: TW]) + 1);

      // R11: start while busy is ignored.
      @(negedge clk);
      pr[0] = enc(3, 1, 2, 3); pr[1] = enc(0, 1, 4, 5);
      prog_len_i = 5'd2;
      prog_i[0 +: IW] = pr[0]; prog_i[IW +: IW] = pr[1];
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      @(negedge clk); @(negedge clk);
      prog_i[0 +: IW] = enc(0, 7, 7, 7);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      while (!done_o) @(negedge clk);
      model(2);
      chk("R11", "restart ignored wo[1]", int'(wo_cyc_o[1*TW +: TW]), e_wo[1]);
      chk("R11", "restart ignored r7", int'(rf_o[7*W +: W]), int'(e_rf[7]));

      // R8: short writer behind long writer of the same register.
      pr[0] = enc(3, 1, 2, 3); pr[1] = enc(0, 1, 4, 5);
      run_prog(2, "waw");
      chk("R8", "late writer lands last", int'(wo_cyc_o[1*TW +: TW]), int'(wo_cyc_o[0*TW +: TW]) + 1);

      // R9: independent divides fill the queue.
      for (int i = 0; i < 6; i++) pr[i] = enc(3, 1 + (i % 6), 0, 7);
      ri[0] = 16'd1000; ri[7] = 16'd9;
      run_prog(6, "fill");
      chk("R9", "fifth waits for first write", int'(of_cyc_o[4*TW +: TW]), int'(wo_cyc_o[0*TW +: TW]) + 1);

      // R10: zero divisor and wrap.
      ri[0] = 16'd0; ri[1] = 16'hFFFF; ri[2] = 16'd2;
      pr[0] = enc(3, 3, 1, 0); pr[1] = enc(0, 4, 1, 2); pr[2] = enc(1, 5, 0, 2); pr[3] = enc(2, 6, 1, 1);
      run_prog(4, "arith");
      chk("R10", "divide by zero", int'(rf_o[3*W +: W]), 16'hFFFF);

      // Random programs on few registers to force hazards.
      for (int t = 0; t < 40; t++) begin
         int n;
         n = 1 + int'($urandom % DEPTH);
         for (int r = 0; r < REGS; r++) ri[r] = ($urandom % 4 == 0) ? '0 : W'($urandom);
         for (int i = 0; i < n; i++)
            pr[i] = enc(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 8));
         run_prog(n, $sformatf("rnd%0d", t));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule